// File: doc/BRIEF.md
# Complementary PWM Pair with Dead-Band Insertion

This block drives one half-bridge: a high-side and a low-side switch. A single edge-aligned counter sets the period. The high side is requested while the count is below the duty value, and the low side is requested for the rest of the period. A dead-band sequencer sits between that raw request and the two output pins. It makes sure a switch turns on only after its partner has been off for a programmed number of clocks.

Period, duty and dead-band values are loaded with a strobe into a shadow bank. The values in use change only when a new period starts, so a write never cuts a pulse short. Clearing the enable does not stop the outputs at once: the current period runs to its end, and then both outputs go off.

The timebase has three states:
- `TB_IDLE`: stopped, count held at 0.
- `TB_RUN`: counting.
- `TB_DRAIN`: enable dropped, finishing the current period.

Its transitions:
- IDLE to RUN on enable.
- RUN to DRAIN when the enable falls before the last count.
- DRAIN to RUN when the enable returns before the last count.
- RUN or DRAIN to IDLE at the last count when the enable is low.
- RUN to RUN at the last count when the enable is high.

The sequencer has five states: `DB_OFF`, `DB_HI`, `DB_GAP_HI` (both off, heading to high), `DB_LO` and `DB_GAP_LO` (both off, heading to low). Its transitions:
- OFF to a gap state, picked by the raw request.
- HI to GAP_LO when the request falls.
- LO to GAP_HI when the request rises.
- A gap state to the side it heads for once the gap count has run out.
- A gap state back to the side it left if the request flips back first.
- Any state to OFF when the timebase is idle.

If the dead-band value is zero, the gap states are skipped.

Top module: `cpwm_pair`

## Requirements
- R1: While reset is asserted, and after it until the block is enabled, hs_out, ls_out and pd_tick are low. The counter is cleared.
- R2: load_stb copies period_in, duty_in and dead_in into the shadow bank. The active values take the shadow contents only when a new period starts, or when the block starts from idle. The period in progress keeps its old duty and length.
- R3: The counter runs from 0 to P-1, where P is the active period; a P of 0 or 1 behaves as 1. pd_tick is high for one cycle at the first cycle of each new period, so ticks are exactly P cycles apart.
- R4: In steady state with 0 < D < P, where D is the duty value and T is the dead-band value, and T < D and T < P-D, hs_out is high for D-T cycles per period and ls_out for P-D-T cycles.
- R5: hs_out and ls_out are never high in the same cycle.
- R6: Each output rises only after the other has been low for at least T cycles. In steady state there are exactly 2*T both-off cycles per period.
- R7: With T = 0, the outputs are exact complements: hs_out is high for D cycles and ls_out for P-D cycles.
- R8: With D = 0, hs_out stays low and ls_out stays high for the whole period.
- R9: With D >= P, hs_out stays high for the whole period and ls_out stays low, with no both-off gap.
- R10: If the off time P-D is shorter than T, ls_out never turns on. hs_out returns as soon as its request returns, giving D high cycles and P-D both-off cycles per period.
- R11: When run_en is cleared, the current period completes with normal output and a final pd_tick. From the next cycle on, both outputs and pd_tick stay low.
- R12: Setting run_en while idle starts the count at 0. The first turn-on is delayed by T cycles: hs_out first goes high T+2 cycles after the enabling edge, and the first pd_tick comes P+1 cycles after it.
- R13: If run_en is set again before a draining period ends, counting continues without a stop. The next period has the normal steady-state output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable; a stop takes effect at the end of the period |
| load_stb | input | 1 | Loads the three setting inputs into the shadow bank |
| period_in | input | CNT_W | Period length in clocks |
| duty_in | input | CNT_W | High-side request length in clocks |
| dead_in | input | DT_W | Dead-band length in clocks |
| hs_out | output | 1 | High-side drive |
| ls_out | output | 1 | Low-side drive |
| pd_tick | output | 1 | One-cycle pulse at each new period |

## Verification
The hardest situations to reach are the drain and resume paths, and a duty write that lands in the middle of a period. Each depends on where in the period the stimulus arrives. The bench locks onto pd_tick and then counts samples inside a measuring window of exactly one period. At a chosen sample it drops or raises run_en, or strobes new values. Counting the high, low and both-off cycles of that window and the next one shows whether the change landed in the correct period.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Timebase run control
    typedef enum logic [1:0] {
        TB_IDLE  = 2'd0,
        TB_RUN   = 2'd1,
        TB_DRAIN = 2'd2
    } tb_state_e;

    // Dead-band sequencer
    typedef enum logic [2:0] {
        DB_OFF    = 3'd0,
        DB_HI     = 3'd1,
        DB_GAP_LO = 3'd2,
        DB_LO     = 3'd3,
        DB_GAP_HI = 3'd4
    } db_state_e;

endpackage

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [DT_W-1:0]  dead_in,
    input  logic             commit,
    output logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] act_duty,
    output logic [DT_W-1:0]  act_dead
);

    logic [CNT_W-1:0] sh_per;
    logic [CNT_W-1:0] sh_duty;
    logic [DT_W-1:0]  sh_dead;

    // A strobe in the same cycle as a commit is forwarded directly
    logic [CNT_W-1:0] src_per;
    logic [CNT_W-1:0] src_duty;
    logic [DT_W-1:0]  src_dead;

    always_comb begin
        src_per  = load_stb ? period_in : sh_per;
        src_duty = load_stb ? duty_in   : sh_duty;
        src_dead = load_stb ? dead_in   : sh_dead;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_per  <= '0;
            sh_duty <= '0;
            sh_dead <= '0;
        end else if (load_stb) begin
            sh_per  <= period_in;
            sh_duty <= duty_in;
            sh_dead <= dead_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_per  <= '0;
            act_duty <= '0;
            act_dead <= '0;
        end else if (commit) begin
            act_per  <= src_per;
            act_duty <= src_duty;
            act_dead <= src_dead;
        end
    end

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             idle,
    output logic             commit,
    output logic             pd_tick
);

    localparam int EXT_W = CNT_W + 1;

    tb_state_e state, state_nxt;
    logic      terminal;
    logic      wrap;

    // Last count of the period; period values 0 and 1 both end every cycle
    assign terminal = ({1'b0, cnt} + EXT_W'(1)) >= {1'b0, act_per};

    always_comb begin
        state_nxt = state;
        commit    = 1'b0;
        wrap      = 1'b0;
        unique case (state)
            TB_IDLE: begin
                if (run_en) begin
                    state_nxt = TB_RUN;
                    commit    = 1'b1;
                end
            end
            TB_RUN: begin
                if (terminal) begin
                    commit    = 1'b1;
                    wrap      = 1'b1;
                    state_nxt = run_en ? TB_RUN : TB_IDLE;
                end else if (!run_en) begin
                    state_nxt = TB_DRAIN;
                end
            end
            TB_DRAIN: begin
                if (terminal) begin
                    commit    = 1'b1;
                    wrap      = 1'b1;
                    state_nxt = run_en ? TB_RUN : TB_IDLE;
                end else if (run_en) begin
                    state_nxt = TB_RUN;
                end
            end
            default: state_nxt = TB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TB_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pd_tick <= 1'b0;
        end else begin
            pd_tick <= wrap;
            if (state == TB_IDLE || wrap) cnt <= '0;
            else                          cnt <= cnt + CNT_W'(1);
        end
    end

    assign running = (state != TB_IDLE);
    assign idle    = (state == TB_IDLE);

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] act_duty,
    input  logic [DT_W-1:0]  act_dead,
    output logic             hs_out,
    output logic             ls_out
);

    db_state_e       state, state_nxt;
    logic [DT_W-1:0] gap, gap_nxt;
    logic            raw_hi;
    logic            dead_zero;

    assign raw_hi    = running && (cnt < act_duty);
    assign dead_zero = (act_dead == '0);

    always_comb begin
        state_nxt = state;
        gap_nxt   = gap;
        if (!running) begin
            state_nxt = DB_OFF;
            gap_nxt   = '0;
        end else begin
            unique case (state)
                DB_OFF: begin
                    gap_nxt = act_dead;
                    if (raw_hi) state_nxt = dead_zero ? DB_HI : DB_GAP_HI;
                    else        state_nxt = dead_zero ? DB_LO : DB_GAP_LO;
                end
                DB_HI: begin
                    if (!raw_hi) begin
                        gap_nxt   = act_dead;
                        state_nxt = dead_zero ? DB_LO : DB_GAP_LO;
                    end
                end
                DB_GAP_LO: begin
                    if (raw_hi)              state_nxt = DB_HI;
                    else if (gap <= DT_W'(1)) state_nxt = DB_LO;
                    else                     gap_nxt   = gap - DT_W'(1);
                end
                DB_LO: begin
                    if (raw_hi) begin
                        gap_nxt   = act_dead;
                        state_nxt = dead_zero ? DB_HI : DB_GAP_HI;
                    end
                end
                DB_GAP_HI: begin
                    if (!raw_hi)             state_nxt = DB_LO;
                    else if (gap <= DT_W'(1)) state_nxt = DB_HI;
                    else                     gap_nxt   = gap - DT_W'(1);
                end
                default: state_nxt = DB_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DB_OFF;
            gap   <= '0;
        end else begin
            state <= state_nxt;
            gap   <= gap_nxt;
        end
    end

    // Drives come straight from flops so they cannot glitch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_out <= 1'b0;
            ls_out <= 1'b0;
        end else begin
            hs_out <= (state_nxt == DB_HI);
            ls_out <= (state_nxt == DB_LO);
        end
    end

endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [DT_W-1:0]  dead_in,
    output logic             hs_out,
    output logic             ls_out,
    output logic             pd_tick
);

    logic [CNT_W-1:0] act_per;
    logic [CNT_W-1:0] act_duty;
    logic [DT_W-1:0]  act_dead;
    logic [CNT_W-1:0] cnt;
    logic             tb_running;
    logic             tb_idle;
    logic             tb_commit;

    cpwm_shadow #(.CNT_W(CNT_W), .DT_W(DT_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_stb  (load_stb),
        .period_in (period_in),
        .duty_in   (duty_in),
        .dead_in   (dead_in),
        .commit    (tb_commit),
        .act_per   (act_per),
        .act_duty  (act_duty),
        .act_dead  (act_dead)
    );

    cpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .act_per (act_per),
        .cnt     (cnt),
        .running (tb_running),
        .idle    (tb_idle),
        .commit  (tb_commit),
        .pd_tick (pd_tick)
    );

    cpwm_deadband #(.CNT_W(CNT_W), .DT_W(DT_W)) u_deadband (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (tb_running),
        .cnt      (cnt),
        .act_duty (act_duty),
        .act_dead (act_dead),
        .hs_out   (hs_out),
        .ls_out   (ls_out)
    );

endmodule

// File: rtl/cpwm_pair_chk.sv
module cpwm_pair_chk #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hs_out,
    input logic             ls_out,
    input logic             pd_tick,
    input logic             idle,
    input logic [CNT_W-1:0] act_duty,
    input logic [DT_W-1:0]  act_dead
);

    localparam logic [DT_W:0] RUN_MAX = '1;

    logic [DT_W:0] ls_off_run;
    logic [DT_W:0] hs_off_run;

    // Consecutive cycles each drive has been low, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_off_run <= RUN_MAX;
            hs_off_run <= RUN_MAX;
        end else begin
            if (ls_out)                    ls_off_run <= '0;
            else if (ls_off_run != RUN_MAX) ls_off_run <= ls_off_run + 1'b1;
            if (hs_out)                    hs_off_run <= '0;
            else if (hs_off_run != RUN_MAX) hs_off_run <= hs_off_run + 1'b1;
        end
    end

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_out && ls_out));

    // R6
    hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_out) |-> (ls_off_run >= {1'b0, act_dead}));

    // R6
    ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_out) |-> (hs_off_run >= {1'b0, act_dead}));

    // R2
    duty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_duty) |-> (pd_tick || $past(idle)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> (!hs_out && !ls_out));

endmodule

bind cpwm_pair cpwm_pair_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_out   (hs_out),
    .ls_out   (ls_out),
    .pd_tick  (pd_tick),
    .idle     (tb_idle),
    .act_duty (act_duty),
    .act_dead (act_dead)
);

// File: tb/tb_cpwm_pair.sv
module tb_cpwm_pair;

    localparam int CNT_W = 16;
    localparam int DT_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_en = 1'b0;
    logic             load_stb = 1'b0;
    logic [CNT_W-1:0] period_in = '0;
    logic [CNT_W-1:0] duty_in = '0;
    logic [DT_W-1:0]  dead_in = '0;
    logic             hs_out;
    logic             ls_out;
    logic             pd_tick;

    int n_chk = 0;
    int n_err = 0;
    int overlaps = 0;

    always #10 clk = ~clk;

    cpwm_pair #(.CNT_W(CNT_W), .DT_W(DT_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .load_stb  (load_stb),
        .period_in (period_in),
        .duty_in   (duty_in),
        .dead_in   (dead_in),
        .hs_out    (hs_out),
        .ls_out    (ls_out),
        .pd_tick   (pd_tick)
    );

    always @(negedge clk) if (rst_n && hs_out && ls_out) overlaps++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0; load_stb = 1'b0;
        period_in = '0; duty_in = '0; dead_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(input int p, input int d, input int t);
        @(negedge clk);
        period_in = CNT_W'(p); duty_in = CNT_W'(d); dead_in = DT_W'(t);
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic sync(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!pd_tick && waited < 3000);
    endtask

    // One period of samples, starting on a pd_tick sample
    task automatic window(input int p, input int strobe_at, input int np, input int nd,
                          input int drop_at, input int raise_at,
                          output int hs_n, output int ls_n, output int off_n, output int tk_n);
        hs_n = 0; ls_n = 0; off_n = 0; tk_n = 0;
        for (int i = 0; i < p; i++) begin
            if (i > 0) @(negedge clk);
            hs_n  += int'(hs_out);
            ls_n  += int'(ls_out);
            off_n += int'(!hs_out && !ls_out);
            tk_n  += int'(pd_tick);
            if (i == strobe_at) begin
                period_in = CNT_W'(np); duty_in = CNT_W'(nd); load_stb = 1'b1;
            end
            if (i == strobe_at + 1) load_stb = 1'b0;
            if (i == drop_at)  run_en = 1'b0;
            if (i == raise_at) run_en = 1'b1;
        end
    endtask

    // Start and measure the second full period
    task automatic steady(input string req, input int p, input int d, input int t,
                          input int e_hs, input int e_ls, input int e_off);
        int w, h, l, o, k;
        do_reset();
        load(p, d, t);
        run_en = 1'b1;
        sync(w);
        window(p, -9, 0, 0, -9, -9, h, l, o, k);
        sync(w);
        window(p, -9, 0, 0, -9, -9, h, l, o, k);
        chk({req, " hs cycles"}, h, e_hs);
        chk({req, " ls cycles"}, l, e_ls);
        chk({req, " both-off cycles"}, o, e_off);
    endtask

    task automatic t_reset();
        int seen;
        seen = 0;
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            seen += int'(hs_out) + int'(ls_out) + int'(pd_tick);
        end
        rst_n = 1'b1;
        repeat (20) begin
            @(negedge clk);
            seen += int'(hs_out) + int'(ls_out) + int'(pd_tick);
        end
        chk("R1 outputs low in and after reset", seen, 0);
    endtask

    task automatic t_start();
        int first_hs, first_tk;
        do_reset();
        load(40, 15, 3);
        run_en = 1'b1;
        first_hs = 0; first_tk = 0;
        for (int s = 1; s <= 45; s++) begin
            @(negedge clk);
            if (hs_out && first_hs == 0) first_hs = s;
            if (pd_tick && first_tk == 0) first_tk = s;
        end
        chk("R12 first hs sample", first_hs, 5);
        chk("R12 first pd_tick sample (counter from 0)", first_tk, 41);
    endtask

    task automatic t_period();
        int w, h, l, o, k;
        do_reset();
        load(40, 15, 4);
        run_en = 1'b1;
        sync(w);
        window(40, -9, 0, 0, -9, -9, h, l, o, k);
        chk("R3 ticks inside period", k, 1);
        sync(w);
        chk("R3 tick spacing", w, 1);
    endtask

    task automatic t_tiny(input int p);
        int ones;
        do_reset();
        load(p, 1, 0);
        run_en = 1'b1;
        repeat (3) @(negedge clk);
        ones = 0;
        repeat (6) begin
            @(negedge clk);
            ones += int'(pd_tick);
        end
        chk("R3 tiny period ticks every cycle", ones, 6);
    endtask

    task automatic t_update();
        int w, h, l, o, k;
        do_reset();
        load(40, 10, 2);
        run_en = 1'b1;
        sync(w);
        window(40, -9, 0, 0, -9, -9, h, l, o, k);
        sync(w);
        window(40, 5, 40, 25, -9, -9, h, l, o, k);
        chk("R2 current period keeps old duty", h, 8);
        sync(w);
        window(40, -9, 0, 0, -9, -9, h, l, o, k);
        chk("R2 next period hs uses new duty", h, 23);
        chk("R2 next period ls uses new duty", l, 13);
        // period change through the shadow bank
        sync(w);
        window(40, 3, 30, 10, -9, -9, h, l, o, k);
        sync(w);
        chk("R2 old period length kept", w, 1);
        window(30, -9, 0, 0, -9, -9, h, l, o, k);
        sync(w);
        chk("R2 new period length applied", w, 1);
        chk("R2 hs in new period", h, 8);
    endtask

    task automatic t_stop();
        int w, h, l, o, k, seen;
        do_reset();
        load(30, 12, 3);
        run_en = 1'b1;
        sync(w);
        window(30, -9, 0, 0, -9, -9, h, l, o, k);
        sync(w);
        window(30, -9, 0, 0, 0, -9, h, l, o, k);
        chk("R11 draining period hs", h, 9);
        chk("R11 draining period ls", l, 15);
        sync(w);
        chk("R11 final tick at period end", w, 1);
        seen = 0;
        repeat (10) begin
            @(negedge clk);
            seen += int'(hs_out) + int'(ls_out) + int'(pd_tick);
        end
        chk("R11 quiet after stop", seen, 0);
    endtask

    task automatic t_resume();
        int w, h, l, o, k;
        do_reset();
        load(30, 12, 3);
        run_en = 1'b1;
        sync(w);
        window(30, -9, 0, 0, -9, -9, h, l, o, k);
        sync(w);
        window(30, -9, 0, 0, 0, 10, h, l, o, k);
        sync(w);
        chk("R13 tick on time after resume", w, 1);
        window(30, -9, 0, 0, -9, -9, h, l, o, k);
        chk("R13 hs continues", h, 9);
        chk("R13 ls continues", l, 15);
    endtask

    initial begin
        t_reset();
        t_start();
        t_period();
        t_tiny(0);
        t_tiny(1);
        steady("R4 R6", 40, 15, 4, 11, 21, 8);
        steady("R7", 20, 7, 0, 7, 13, 0);
        steady("R8", 16, 0, 3, 0, 16, 0);
        steady("R9", 16, 16, 3, 16, 0, 0);
        steady("R9 over", 16, 40, 3, 16, 0, 0);
        steady("R10", 20, 15, 8, 15, 0, 5);
        t_update();
        t_stop();
        t_resume();
        chk("R5 overlap cycles", overlaps, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule